// File: doc/BRIEF.md
# Ordered-Group Write Buffer with Read Bypass

This block sits between a processor and a memory bus. It holds processor writes in an eight-entry first-in first-out queue and sends them to memory on its own, so the processor does not wait for write latency. Reads go straight through to the memory read port while the queue holds writes. The exception is a read whose address equals the address of a write that is still pending. That read is held off until memory has acknowledged that write.

The processor can also push a fence marker into the same queue. Markers divide the buffered writes into groups. Writes of the group at the front of the queue are launched in program order. Up to two of them may be in flight at once, and memory may acknowledge them in any order, so their completion can differ from program order. No write behind a marker is launched until every write ahead of the marker has been acknowledged.

Top module: `wbuf_fence`

## Requirements
- R1: A read whose address matches no pending buffered write (a write not yet acknowledged) passes through in the same cycle: `mem_rd_valid` equals `rd_valid` and `rd_ready` equals `mem_rd_ready`. `rd_data` and `rd_data_valid` mirror `mem_rd_data` and `mem_rd_data_valid`.
- R2: A read whose address equals that of any pending buffered write is stalled: `mem_rd_valid` and `rd_ready` stay 0 until the cycle after the acknowledge of the last such write.
- R3: Writes are launched on `mw_req` in the program order in which they were accepted. An offer is taken when `mw_req` and `mw_gnt` are both 1.
- R4: A write accepted after a fence marker (`in_barrier`=1) is not offered until every write accepted before that marker has been acknowledged.
- R5: A write counts as complete only when `mw_ack` returns with `mw_ack_id` equal to the ID it was launched with. Until then its address keeps blocking matching reads.
- R6: At most two writes are outstanding. A launch uses the lowest free ID out of 0 and 1. A second write of the same group is launched without waiting for the first acknowledge, and acknowledges may arrive in either order.
- R7: The queue holds 8 entries, and fence markers occupy entries too. `in_ready` is 0 while 8 entries are held, and no input is accepted then.
- R8: Reset discards every queued entry and every outstanding ID. Afterwards `in_ready` is 1, `mw_req` is 0, and no earlier write blocks a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Processor offers a write or a fence marker |
| in_barrier | input | 1 | 1: the offered entry is a fence marker |
| in_addr | input | AW | Write address |
| in_data | input | DW | Write data |
| in_ready | output | 1 | Queue can accept an entry |
| rd_valid | input | 1 | Processor read request |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read accepted toward memory |
| rd_data | output | DW | Read data returned from memory |
| rd_data_valid | output | 1 | Read data valid |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_addr | output | AW | Read address to memory |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_data | input | DW | Read data from memory |
| mem_rd_data_valid | input | 1 | Memory read data valid |
| mw_req | output | 1 | Write offered to memory |
| mw_addr | output | AW | Offered write address |
| mw_data | output | DW | Offered write data |
| mw_id | output | IW | Tracking ID of the offered write |
| mw_gnt | input | 1 | Memory takes the offered write |
| mw_ack | input | 1 | Memory reports a write complete |
| mw_ack_id | input | IW | ID of the completed write |

## Verification
The embedded properties watch four things on every cycle. A fence leaves the queue only when no write is in flight. Every acknowledge names a busy ID. A full queue never grows. The first cycle after reset shows an empty, idle block. Launch order, the fence hold on later groups, the two-ID limit, read stalls on address conflicts, and the final memory image are shown only by the bench's scenarios. The bench compares these with its own record of accepted, launched and acknowledged writes while memory grants and acknowledges at random.

// File: rtl/wbuf_fence.sv
module wbuf_fence #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int NOUT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_barrier,
  input  logic [AW-1:0]                 in_addr,
  input  logic [DW-1:0]                 in_data,
  output logic                          in_ready,
  input  logic                          rd_valid,
  input  logic [AW-1:0]                 rd_addr,
  output logic                          rd_ready,
  output logic [DW-1:0]                 rd_data,
  output logic                          rd_data_valid,
  output logic                          mem_rd_valid,
  output logic [AW-1:0]                 mem_rd_addr,
  input  logic                          mem_rd_ready,
  input  logic [DW-1:0]                 mem_rd_data,
  input  logic                          mem_rd_data_valid,
  output logic                          mw_req,
  output logic [AW-1:0]                 mw_addr,
  output logic [DW-1:0]                 mw_data,
  output logic [$clog2(NOUT)-1:0]       mw_id,
  input  logic                          mw_gnt,
  input  logic                          mw_ack,
  input  logic [$clog2(NOUT)-1:0]       mw_ack_id
);
  localparam int PW = $clog2(DEPTH);
  localparam int IW = $clog2(NOUT);

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [DEPTH-1:0] e_val, e_bar, e_lau, e_done;
  logic [PW-1:0]    head, tail;
  logic [PW:0]      count;
  logic [NOUT-1:0]  s_busy;
  logic [PW-1:0]    s_idx [NOUT];

  logic             conflict, found, sfree, push, pop, launch;
  logic [PW-1:0]    cand;
  logic [IW-1:0]    sid;

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (e_val[i] && !e_bar[i] && !e_done[i] && e_addr[i] == rd_addr) conflict = 1'b1;
  end

  always_comb begin
    logic          stop;
    logic [PW-1:0] idx;
    found = 1'b0;
    stop  = 1'b0;
    cand  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (!stop && !found && e_val[idx]) begin
        if (e_bar[idx]) stop = 1'b1;
        else if (!e_lau[idx]) begin
          found = 1'b1;
          cand  = idx;
        end
      end
    end
  end

  always_comb begin
    sfree = 1'b0;
    sid   = '0;
    for (int s = NOUT - 1; s >= 0; s--)
      if (!s_busy[s]) begin
        sfree = 1'b1;
        sid   = IW'(s);
      end
  end

  assign in_ready      = count < (PW+1)'(DEPTH);
  assign push          = in_valid && in_ready;
  assign pop           = e_val[head] && (e_bar[head] || e_done[head]);
  assign mw_req        = found && sfree;
  assign mw_addr       = e_addr[cand];
  assign mw_data       = e_data[cand];
  assign mw_id         = sid;
  assign launch        = mw_req && mw_gnt;
  assign mem_rd_valid  = rd_valid && !conflict;
  assign mem_rd_addr   = rd_addr;
  assign rd_ready      = mem_rd_ready && !conflict;
  assign rd_data       = mem_rd_data;
  assign rd_data_valid = mem_rd_data_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_val  <= '0;
      e_bar  <= '0;
      e_lau  <= '0;
      e_done <= '0;
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      s_busy <= '0;
    end else begin
      if (push) begin
        e_val[tail]  <= 1'b1;
        e_bar[tail]  <= in_barrier;
        e_lau[tail]  <= 1'b0;
        e_done[tail] <= 1'b0;
        e_addr[tail] <= in_addr;
        e_data[tail] <= in_data;
        tail         <= tail + 1'b1;
      end
      if (pop) begin
        e_val[head] <= 1'b0;
        head        <= head + 1'b1;
      end
      if (launch) begin
        e_lau[cand] <= 1'b1;
        s_busy[sid] <= 1'b1;
        s_idx[sid]  <= cand;
      end
      if (mw_ack) begin
        s_busy[mw_ack_id]        <= 1'b0;
        e_done[s_idx[mw_ack_id]] <= 1'b1;
      end
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  // R4: a fence leaves the queue only after all earlier writes completed
  p_bar_pop_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && e_bar[head]) |-> (s_busy == '0));

  // R5: completion only for a write actually in flight under that ID
  p_ack_tracked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mw_ack |-> s_busy[mw_ack_id]);

  // R7: a full queue accepts nothing
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (count <= $past(count)));

  // R8: first cycle out of reset is empty and idle
  p_reset_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (in_ready && !mw_req && s_busy == '0));
endmodule

// File: tb/wbuf_fence_tb.sv
module wbuf_fence_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NMAX = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_barrier = 0, rd_valid = 0, mem_rd_ready = 0, mem_rd_data_valid = 0;
  logic [AW-1:0] in_addr = '0, rd_addr = '0;
  logic [DW-1:0] in_data = '0, mem_rd_data = '0;
  logic mw_gnt = 0, mw_ack = 0;
  logic [0:0] mw_ack_id = '0;
  logic in_ready, rd_ready, rd_data_valid, mem_rd_valid, mw_req;
  logic [DW-1:0] rd_data, mw_data;
  logic [AW-1:0] mem_rd_addr, mw_addr;
  logic [0:0] mw_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_fence #(.AW(AW), .DW(DW), .DEPTH(8), .NOUT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_barrier(in_barrier),
    .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data), .mem_rd_data_valid(mem_rd_data_valid),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_id(mw_id),
    .mw_gnt(mw_gnt), .mw_ack(mw_ack), .mw_ack_id(mw_ack_id));

  int n_chk = 0, n_fail = 0;
  int n_acc = 0, next_launch = 0, cur_grp = 0;
  int b_addr [NMAX];
  int b_grp  [NMAX];
  bit b_bar [NMAX], b_ack [NMAX], b_flush [NMAX];
  bit id_busy [2];
  int id_seq [2];
  int mem_img [16];
  int gnt_mode = 1;
  bit ack_en = 1;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pending_at(input int a);
    for (int j = 0; j < n_acc; j++)
      if (!b_bar[j] && !b_ack[j] && !b_flush[j] && b_addr[j] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit all_acked();
    for (int j = 0; j < n_acc; j++)
      if (!b_bar[j] && !b_ack[j] && !b_flush[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic monitor();
    if (rd_valid) begin
      bit c;
      c = pending_at(int'(rd_addr));
      if (c) begin
        check(!mem_rd_valid && !rd_ready, "R2 stalled read", int'(rd_ready), 0);
      end else begin
        check(mem_rd_valid && rd_ready == mem_rd_ready, "R1 bypass read", int'(rd_ready), int'(mem_rd_ready));
        check(rd_data == mem_rd_data && rd_data_valid == mem_rd_data_valid, "R1 read data", int'(rd_data), int'(mem_rd_data));
      end
    end
    if (mw_req && mw_gnt) begin
      int s;
      bit early;
      while (next_launch < n_acc && (b_bar[next_launch] || b_flush[next_launch])) next_launch++;
      s = int'(mw_data);
      check(s == next_launch, "R3 launch order", s, next_launch);
      if (s >= 0 && s < n_acc) begin
        early = 1'b0;
        for (int j = 0; j < s; j++)
          if (!b_bar[j] && !b_flush[j] && !b_ack[j] && b_grp[j] < b_grp[s]) early = 1'b1;
        check(!early, "R4 launch across fence", int'(early), 0);
        check(int'(mw_addr) == b_addr[s], "R3 launch address", int'(mw_addr), b_addr[s]);
        mem_img[b_addr[s] % 16] = s;
      end
      check(!id_busy[mw_id], "R6 free id used", int'(id_busy[mw_id]), 0);
      check(mw_id == 0 || id_busy[0], "R6 lowest free id", int'(mw_id), 0);
      id_busy[mw_id] = 1'b1;
      id_seq[mw_id] = s;
      next_launch = s + 1;
    end
    if (mw_ack) begin
      b_ack[id_seq[mw_ack_id]] = 1'b1;
      id_busy[mw_ack_id] = 1'b0;
    end
    if (in_valid && in_ready) begin
      b_addr[n_acc] = int'(in_addr);
      b_bar[n_acc] = in_barrier;
      b_grp[n_acc] = cur_grp;
      b_ack[n_acc] = 1'b0;
      b_flush[n_acc] = 1'b0;
      if (in_barrier) cur_grp++;
      n_acc++;
    end
  endtask

  task automatic step(input bit iv, input bit ib, input int ia, input bit rv, input int ra);
    @(negedge clk);
    in_valid = iv;
    in_barrier = ib;
    in_addr = AW'(ia);
    in_data = DW'(n_acc);
    rd_valid = rv;
    rd_addr = AW'(ra);
    mem_rd_ready = 1'($urandom % 4 != 0);
    mem_rd_data = DW'($urandom);
    mem_rd_data_valid = 1'($urandom % 2);
    mw_gnt = (gnt_mode == 0) ? 1'b0 : (gnt_mode == 1) ? 1'b1 : 1'($urandom % 4 != 0);
    mw_ack = 1'b0;
    if (ack_en && (id_busy[0] || id_busy[1]) && ($urandom % 2 == 0)) begin
      mw_ack = 1'b1;
      if (id_busy[0] && id_busy[1]) mw_ack_id = 1'($urandom % 2);
      else mw_ack_id = id_busy[1] ? 1'b1 : 1'b0;
    end
    #1;
    monitor();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    ack_en = 1;
    gnt_mode = 1;
    for (int i = 0; i < 300 && !all_acked(); i++) idle(1);
    idle(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem_img[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8 reset in_ready", int'(in_ready), 1);
    check(mw_req == 1'b0, "R8 reset mw_req", int'(mw_req), 0);

    // R6 and R3: two writes in flight, third held; R2 stall on a pending address
    ack_en = 0; gnt_mode = 1;
    step(1, 0, 1, 0, 0);
    step(1, 0, 2, 0, 0);
    step(1, 0, 3, 0, 0);
    idle(5);
    check(mw_req == 1'b0, "R6 third write held", int'(mw_req), 0);
    check(id_busy[0] && id_busy[1], "R6 two outstanding", int'(id_busy[0]) + int'(id_busy[1]), 2);
    step(0, 0, 0, 1, 1);
    check(rd_ready == 1'b0 && mem_rd_valid == 1'b0, "R2 read held on addr 1", int'(mem_rd_valid), 0);
    step(0, 0, 0, 1, 9);
    check(mem_rd_valid == 1'b1, "R1 read addr 9 passes", int'(mem_rd_valid), 1);
    drain();
    step(0, 0, 0, 1, 1);
    check(mem_rd_valid == 1'b1, "R5 read passes after ack", int'(mem_rd_valid), 1);

    // R4: write behind a fence waits for the earlier write
    ack_en = 0;
    step(1, 0, 4, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 0, 5, 0, 0);
    idle(5);
    check(mw_req == 1'b0, "R4 write after fence held", int'(mw_req), 0);
    check(id_busy[0] && !id_busy[1], "R4 only first launched", int'(id_busy[1]), 0);
    drain();

    // R7: queue full at eight entries, fences counted
    gnt_mode = 0; ack_en = 0;
    for (int i = 0; i < 8; i++) begin
      step(1, (i == 2 || i == 5), 8 + i, 0, 0);
      check(in_ready == 1'b1, "R7 ready below full", int'(in_ready), 1);
    end
    step(1, 0, 15, 0, 0);
    check(in_ready == 1'b0, "R7 full back-pressure", int'(in_ready), 0);
    drain();

    // R8: reset mid-flight flushes queue and trackers
    gnt_mode = 1; ack_en = 0;
    step(1, 0, 7, 0, 0);
    step(1, 0, 6, 0, 0);
    gnt_mode = 0;
    step(1, 0, 7, 0, 0);
    idle(3);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 0;
    idle(2);
    for (int j = 0; j < n_acc; j++) if (!b_ack[j]) b_flush[j] = 1'b1;
    id_busy[0] = 0; id_busy[1] = 0;
    next_launch = n_acc;
    for (int i = 0; i < 16; i++) mem_img[i] = -1;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 7);
    check(in_ready == 1'b1 && mw_req == 1'b0, "R8 empty after reset", int'(mw_req), 0);
    check(mem_rd_valid == 1'b1, "R8 no stale conflict", int'(mem_rd_valid), 1);

    // random phase
    gnt_mode = 2; ack_en = 1;
    for (int i = 0; i < 4000; i++) begin
      bit iv, ib;
      iv = 1'($urandom % 2);
      ib = 1'($urandom % 6 == 0);
      step(iv, ib, int'($urandom % 16), 1'($urandom % 2), int'($urandom % 16));
    end
    drain();
    check(all_acked(), "R5 all writes completed", 0, 1);
    for (int a = 0; a < 16; a++) begin
      int exp;
      exp = -1;
      for (int j = 0; j < n_acc; j++)
        if (!b_bar[j] && !b_flush[j] && b_addr[j] == a) exp = j;
      check(mem_img[a] == exp, "R3 final memory image", mem_img[a], exp);
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule